// File: doc/BRIEF.md
# Display PHY Power-Up Sequencer

This block brings a display transmitter PHY out of reset without help from software. After a single start pulse it builds up the PHY control word one enable bit at a time and lets each bit settle for a set number of microsecond ticks. It then waits, for a bounded time, for the PHY to report that it is ready. Next it loads the PLL and clock words, arms the PLL, and after a long settle it takes a calibration value from the status bus and merges it into the PLL word. It finishes by writing the final control word.

All waits are counted on a one-microsecond tick strobe supplied by the chip, so the block runs from any system clock. Each delay is a parameter, and the counter is sized for the longest of them (100 ms at the defaults). If the ready flag never appears, the sequence still runs to the end and leaves a timeout flag raised. The pixel-clock band input selects whether the calibration value is bumped before it is merged.

Top module: `phy_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start pulse, every output word, `aux_en`, `done` and `timeout` is zero.
- R2: A start pulse in idle clears the control word and then sets control bits one per step in this order, waiting the given number of ticks after each: bit 0 (5), bit 16 (0), bit 1 (10), bit 2 (5), bit 3 (40), bit 19 (100), bit 18 (0), then bits 6:4 together. The control word is then 0x000D007F.
- R3: After bits 6:4 are set, the sequence moves on in the first cycle that status bit 7 is sampled high. `timeout` stays 0.
- R4: If status bit 7 stays low for 2000 ticks of polling, `timeout` is set to 1 and the sequence carries on. `timeout` is cleared by the next start.
- R5: After the poll the block sets control bits 11:8 and then bit 7, which gives a control word of 0x000D0FFF.
- R6: The block then writes the PLL word 0x39dc5040 and the clock word 0x80084343 and waits 10000 ticks. It then raises `aux_en` and sets PLL bit 25, and waits 100000 ticks.
- R7: In the next step the block reads status bits 16:11 as a 6-bit calibration value, sets PLL bits 31 and 30, and ORs the value into PLL bits 5:0. With `high_band` low the value is merged unchanged.
- R8: With `high_band` high at that step, the merged value is the calibration value plus 2, limited to 0x3f.
- R9: The last step writes the control word 0x01FF0F7F and pulses `done` high for exactly one cycle in that same cycle.
- R10: A start pulse that arrives while a sequence is running has no effect. The sequence completes once, with one `done` pulse, and does not restart.
- R11: Waits advance only on cycles where `us_tick` is high. With no ticks the outputs hold their values for as long as the ticks are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a sequence when the block is idle |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| high_band | input | 1 | Highest pixel-clock band; bumps the calibration value |
| status | input | STAT_W (20) | PHY status: bit 7 ready, bits 16:11 calibration |
| ctrl_word | output | 32 | Registered PHY control word |
| pll_word | output | 32 | Registered PLL word |
| clk_word | output | 32 | Registered clock word |
| aux_en | output | 1 | Auxiliary enable, set once the PLL settle ends |
| done | output | 1 | One-cycle pulse when the sequence finishes |
| timeout | output | 1 | Ready poll expired in the latest sequence |

## Verification
The assertions check on every cycle that a tickless wait cycle changes no output word, that `done` lasts one cycle and comes with the final control word, that `timeout` rises only between the bits 6:4 step and the bits 11:8 step, and that the PLL lock bits and the auxiliary enable appear only on top of the words that come before them. The full step order, the exact tick counts between steps, the poll exit on a late ready flag, the calibration arithmetic in both bands with saturation, and the ignored restart only show up in the bench scenarios, where a behavioural model is compared cycle by cycle against the outputs.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ACT,
    SQ_WAIT,
    SQ_POLL
  } sq_state_t;

  localparam int WORD_W = 32;
  localparam int STEP_W = 5;

  // Step indices; the order is the behaviour of the block.
  localparam logic [STEP_W-1:0] ST_CLEAR  = 5'd0;
  localparam logic [STEP_W-1:0] ST_EN0    = 5'd1;
  localparam logic [STEP_W-1:0] ST_EN16   = 5'd2;
  localparam logic [STEP_W-1:0] ST_EN1    = 5'd3;
  localparam logic [STEP_W-1:0] ST_EN2    = 5'd4;
  localparam logic [STEP_W-1:0] ST_EN3    = 5'd5;
  localparam logic [STEP_W-1:0] ST_EN19   = 5'd6;
  localparam logic [STEP_W-1:0] ST_EN18   = 5'd7;
  localparam logic [STEP_W-1:0] ST_DRV    = 5'd8;
  localparam logic [STEP_W-1:0] ST_LANE   = 5'd9;
  localparam logic [STEP_W-1:0] ST_EN7    = 5'd10;
  localparam logic [STEP_W-1:0] ST_PLLW   = 5'd11;
  localparam logic [STEP_W-1:0] ST_CLKW   = 5'd12;
  localparam logic [STEP_W-1:0] ST_AUX    = 5'd13;
  localparam logic [STEP_W-1:0] ST_ARM    = 5'd14;
  localparam logic [STEP_W-1:0] ST_CAL    = 5'd15;
  localparam logic [STEP_W-1:0] ST_FINAL  = 5'd16;

  localparam logic [WORD_W-1:0] PLL_BASE   = 32'h39dc5040;
  localparam logic [WORD_W-1:0] CLK_BASE   = 32'h80084343;
  localparam logic [WORD_W-1:0] CTRL_LAST  = 32'h01FF0F7F;
  localparam logic [WORD_W-1:0] PLL_LOCKS  = 32'hC000_0000;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_en  = clr | tick;
  assign expire  = !clr && tick && (cnt_inc == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/phy_seq_cal.sv
module phy_seq_cal #(
  parameter int CAL_W    = 6,
  parameter int CAL_BUMP = 2
) (
  input  logic [CAL_W-1:0] raw,
  input  logic             hi_band,
  output logic [CAL_W-1:0] adj
);

  localparam logic [CAL_W:0] CAL_MAX = {1'b0, {CAL_W{1'b1}}};

  generate
    if (CAL_BUMP == 0) begin : g_pass
      assign adj = raw;
    end else begin : g_bump
      logic [CAL_W:0] sum;
      assign sum = {1'b0, raw} + (CAL_W+1)'(CAL_BUMP);
      always_comb begin
        if (!hi_band)           adj = raw;
        else if (sum > CAL_MAX) adj = CAL_MAX[CAL_W-1:0];
        else                    adj = sum[CAL_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned D_EN0    = 5,
  parameter int unsigned D_EN1    = 10,
  parameter int unsigned D_EN2    = 5,
  parameter int unsigned D_EN3    = 40,
  parameter int unsigned D_EN19   = 100,
  parameter int unsigned POLL_US  = 2000,
  parameter int unsigned PLL_US   = 10000,
  parameter int unsigned CAL_US   = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              expire,
  input  logic              ready,
  output logic              act,
  output logic [STEP_W-1:0] step,
  output logic              tmr_clr,
  output logic [CNT_W-1:0]  limit,
  output logic              poll_to,
  output logic              in_wait
);

  sq_state_t         state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  cur_dly;

  always_comb begin
    case (step_q)
      ST_EN0:  cur_dly = CNT_W'(D_EN0);
      ST_EN1:  cur_dly = CNT_W'(D_EN1);
      ST_EN2:  cur_dly = CNT_W'(D_EN2);
      ST_EN3:  cur_dly = CNT_W'(D_EN3);
      ST_EN19: cur_dly = CNT_W'(D_EN19);
      ST_CLKW: cur_dly = CNT_W'(PLL_US);
      ST_ARM:  cur_dly = CNT_W'(CAL_US);
      default: cur_dly = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    poll_to = 1'b0;
    case (state_q)
      SQ_IDLE: if (start) begin
        state_d = SQ_ACT;
        step_d  = ST_CLEAR;
      end
      SQ_ACT: begin
        if (step_q == ST_FINAL)     state_d = SQ_IDLE;
        else if (cur_dly != '0)     state_d = SQ_WAIT;
        else if (step_q == ST_DRV)  state_d = SQ_POLL;
        else                        step_d  = step_q + 1'b1;
      end
      SQ_WAIT: if (expire) begin
        state_d = SQ_ACT;
        step_d  = step_q + 1'b1;
      end
      SQ_POLL: begin
        if (ready) begin
          state_d = SQ_ACT;
          step_d  = step_q + 1'b1;
        end else if (expire) begin
          state_d = SQ_ACT;
          step_d  = step_q + 1'b1;
          poll_to = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign act     = (state_q == SQ_ACT);
  assign step    = step_q;
  assign tmr_clr = (state_q == SQ_ACT) || (state_q == SQ_IDLE);
  assign limit   = (state_q == SQ_POLL) ? CNT_W'(POLL_US) : cur_dly;
  assign in_wait = (state_q == SQ_WAIT);

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned D_EN0    = 5,
  parameter int unsigned D_EN1    = 10,
  parameter int unsigned D_EN2    = 5,
  parameter int unsigned D_EN3    = 40,
  parameter int unsigned D_EN19   = 100,
  parameter int unsigned POLL_US  = 2000,
  parameter int unsigned PLL_US   = 10000,
  parameter int unsigned CAL_US   = 100000,
  parameter int          STAT_W   = 20,
  parameter int          RDY_BIT  = 7,
  parameter int          CAL_LSB  = 11,
  parameter int          CAL_W    = 6,
  parameter int          CAL_BUMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              us_tick,
  input  logic              high_band,
  input  logic [STAT_W-1:0] status,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       pll_word,
  output logic [31:0]       clk_word,
  output logic              aux_en,
  output logic              done,
  output logic              timeout
);

  localparam int unsigned MAX_US =
    max2(max2(max2(D_EN0, D_EN1), max2(D_EN2, D_EN3)),
         max2(max2(D_EN19, POLL_US), max2(PLL_US, CAL_US)));
  localparam int CNT_W = $clog2(MAX_US + 1);

  logic              act, tmr_clr, expire, poll_to, in_wait;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  limit;
  logic [CAL_W-1:0]  cal_adj;

  logic [WORD_W-1:0] ctrl_q, ctrl_d, pll_q, pll_d, clk_q, clk_d;
  logic              aux_q, aux_d, done_q, done_d, to_q, to_d;

  phy_seq_fsm #(
    .CNT_W(CNT_W), .D_EN0(D_EN0), .D_EN1(D_EN1), .D_EN2(D_EN2),
    .D_EN3(D_EN3), .D_EN19(D_EN19), .POLL_US(POLL_US),
    .PLL_US(PLL_US), .CAL_US(CAL_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .expire(expire),
    .ready(status[RDY_BIT]), .act(act), .step(step), .tmr_clr(tmr_clr),
    .limit(limit), .poll_to(poll_to), .in_wait(in_wait)
  );

  phy_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(us_tick),
    .limit(limit), .expire(expire)
  );

  phy_seq_cal #(.CAL_W(CAL_W), .CAL_BUMP(CAL_BUMP)) u_cal (
    .raw(status[CAL_LSB +: CAL_W]), .hi_band(high_band), .adj(cal_adj)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    pll_d  = pll_q;
    clk_d  = clk_q;
    aux_d  = aux_q;
    to_d   = to_q;
    done_d = act && (step == ST_FINAL);
    if (act) begin
      case (step)
        ST_CLEAR: begin
          ctrl_d = '0; pll_d = '0; clk_d = '0; aux_d = 1'b0; to_d = 1'b0;
        end
        ST_EN0:   ctrl_d = ctrl_q | 32'h0000_0001;
        ST_EN16:  ctrl_d = ctrl_q | 32'h0001_0000;
        ST_EN1:   ctrl_d = ctrl_q | 32'h0000_0002;
        ST_EN2:   ctrl_d = ctrl_q | 32'h0000_0004;
        ST_EN3:   ctrl_d = ctrl_q | 32'h0000_0008;
        ST_EN19:  ctrl_d = ctrl_q | 32'h0008_0000;
        ST_EN18:  ctrl_d = ctrl_q | 32'h0004_0000;
        ST_DRV:   ctrl_d = ctrl_q | 32'h0000_0070;
        ST_LANE:  ctrl_d = ctrl_q | 32'h0000_0F00;
        ST_EN7:   ctrl_d = ctrl_q | 32'h0000_0080;
        ST_PLLW:  pll_d  = PLL_BASE;
        ST_CLKW:  clk_d  = CLK_BASE;
        ST_AUX:   aux_d  = 1'b1;
        ST_ARM:   pll_d  = pll_q | 32'h0200_0000;
        ST_CAL:   pll_d  = pll_q | PLL_LOCKS | WORD_W'(cal_adj);
        ST_FINAL: ctrl_d = CTRL_LAST;
        default:  ;
      endcase
    end
    if (poll_to) to_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pll_q  <= '0;
      clk_q  <= '0;
      aux_q  <= 1'b0;
    end else if (act) begin
      ctrl_q <= ctrl_d;
      pll_q  <= pll_d;
      clk_q  <= clk_d;
      aux_q  <= aux_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign ctrl_word = ctrl_q;
  assign pll_word  = pll_q;
  assign clk_word  = clk_q;
  assign aux_en    = aux_q;
  assign done      = done_q;
  assign timeout   = to_q;

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        us_tick,
  input logic        in_wait,
  input logic [31:0] ctrl_word,
  input logic [31:0] pll_word,
  input logic [31:0] clk_word,
  input logic        aux_en,
  input logic        done,
  input logic        timeout
);

  // R11: a wait cycle with no tick leaves every word untouched
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !us_tick) |=> ($stable(ctrl_word) && $stable(pll_word) && $stable(clk_word)));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done coincides with the final control word
  a_r9_done_final_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctrl_word == 32'h01FF0F7F));

  // R4: timeout can only rise while the poll is pending
  a_r4_timeout_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ((ctrl_word[6:4] == 3'b111) && (ctrl_word[11:8] == 4'h0)));

  // R6: aux enable follows the PLL and clock words
  a_r6_aux_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_en) |-> ((clk_word == 32'h80084343) && (pll_word == 32'h39dc5040)));

  // R7: lock bits appear only once the PLL is armed
  a_r7_lock_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_word[31]) |-> (pll_word[30] && pll_word[25]));

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .in_wait(in_wait),
  .ctrl_word(ctrl_word), .pll_word(pll_word), .clk_word(clk_word),
  .aux_en(aux_en), .done(done), .timeout(timeout)
);

// File: tb/sim_phy_pwrup_seq.sv
module sim_phy_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T0 = 3, T1 = 4, T2 = 2, T3 = 5, T19 = 6;
  localparam int TPOLL = 20, TPLL = 12, TCAL = 15;

  logic        clk, rst_n, start, us_tick, high_band;
  logic [19:0] status;
  logic [31:0] ctrl_word, pll_word, clk_word;
  logic        aux_en, done, timeout;

  phy_pwrup_seq #(
    .D_EN0(T0), .D_EN1(T1), .D_EN2(T2), .D_EN3(T3), .D_EN19(T19),
    .POLL_US(TPOLL), .PLL_US(TPLL), .CAL_US(TCAL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .high_band(high_band), .status(status), .ctrl_word(ctrl_word),
    .pll_word(pll_word), .clk_word(clk_word), .aux_en(aux_en),
    .done(done), .timeout(timeout)
  );

  int vectors = 0, fails = 0, cyc = 0, ndone = 0, div = 0;
  logic tick_en = 1'b1;
  logic [31:0] e_ctrl = 0, e_pll = 0, e_clk = 0;
  logic e_aux = 0, e_done = 0, e_to = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tick strobe: one cycle in three when enabled
  always @(negedge clk) begin
    if (!rst_n) begin div = 0; us_tick = 1'b0; end
    else begin
      div = (div == 2) ? 0 : div + 1;
      us_tick = tick_en && (div == 0);
    end
  end

  // ---------------- behavioural reference model ----------------
  task automatic ticks(input int n);
    int seen = 0;
    while (seen < n) begin @(posedge clk); if (us_tick) seen++; end
  endtask

  function automatic logic [5:0] cal_of(input logic [19:0] s, input logic hb);
    int v = int'(s[16:11]);
    if (hb) v = (v + 2 > 63) ? 63 : v + 2;
    return 6'(v);
  endfunction

  task automatic model_seq();
    int pc = 0;
    @(posedge clk); e_ctrl = 0; e_pll = 0; e_clk = 0; e_aux = 0; e_to = 0;
    @(posedge clk); e_ctrl |= 32'h1;        ticks(T0);
    @(posedge clk); e_ctrl |= 32'h10000;
    @(posedge clk); e_ctrl |= 32'h2;        ticks(T1);
    @(posedge clk); e_ctrl |= 32'h4;        ticks(T2);
    @(posedge clk); e_ctrl |= 32'h8;        ticks(T3);
    @(posedge clk); e_ctrl |= 32'h80000;    ticks(T19);
    @(posedge clk); e_ctrl |= 32'h40000;
    @(posedge clk); e_ctrl |= 32'h70;
    forever begin
      @(posedge clk);
      if (status[7]) break;
      if (us_tick) pc++;
      if (pc == TPOLL) begin e_to = 1; break; end
    end
    @(posedge clk); e_ctrl |= 32'hF00;
    @(posedge clk); e_ctrl |= 32'h80;
    @(posedge clk); e_pll = 32'h39dc5040;
    @(posedge clk); e_clk = 32'h80084343;   ticks(TPLL);
    @(posedge clk); e_aux = 1;
    @(posedge clk); e_pll |= 32'h02000000;  ticks(TCAL);
    @(posedge clk); e_pll |= 32'hC0000000 | {26'd0, cal_of(status, high_band)};
    @(posedge clk); e_ctrl = 32'h01FF0F7F;  e_done = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      e_done = 0;
      if (rst_n && start) model_seq();
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    if (rst_n) begin
      check(ctrl_word == e_ctrl, "R2 R5 R9 ctrl_word", ctrl_word, e_ctrl);
      check(pll_word == e_pll, "R6 R7 pll_word", pll_word, e_pll);
      check(clk_word == e_clk, "R6 clk_word", clk_word, e_clk);
      check(aux_en == e_aux, "R6 aux_en", 32'(aux_en), 32'(e_aux));
      check(done == e_done, "R9 done", 32'(done), 32'(e_done));
      check(timeout == e_to, "R3 R4 timeout", 32'(timeout), 32'(e_to));
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d cycles expected=done earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_simple(input logic [19:0] st, input logic hb, input logic [31:0] exp_pll, input logic exp_to, input string tag);
    int d0;
    status = st; high_band = hb; d0 = ndone;
    pulse_start();
    wait_done();
    check(pll_word == exp_pll, tag, pll_word, exp_pll);
    check(timeout == exp_to, "R3 R4 timeout at end", 32'(timeout), 32'(exp_to));
    repeat (4) @(negedge clk);
    check(ndone - d0 == 1, "R9 done count", 32'(ndone - d0), 32'd1);
  endtask

  initial begin
    int d0;
    rst_n = 1'b0; start = 1'b0; high_band = 1'b0; status = '0;
    repeat (3) @(negedge clk);
    check(ctrl_word == 0 && pll_word == 0 && clk_word == 0, "R1 words in reset", ctrl_word | pll_word | clk_word, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({aux_en, done, timeout} == 3'b000, "R1 flags after reset", 32'({aux_en, done, timeout}), 0);

    // Scenario A: normal band, late ready, tick pause, ignored restart
    status = 20'h0; status[16:11] = 6'h2b; high_band = 1'b0; d0 = ndone;
    pulse_start();
    repeat (3) @(negedge clk);
    check(ctrl_word == 32'h1, "R11 ctrl before pause", ctrl_word, 32'h1);
    tick_en = 1'b0;
    repeat (20) @(negedge clk);
    check(ctrl_word == 32'h1, "R11 ctrl held without ticks", ctrl_word, 32'h1);
    tick_en = 1'b1;
    pulse_start();  // R10: must be ignored
    while (!ctrl_word[6]) @(negedge clk);
    check(ctrl_word == 32'h000D007F, "R2 ctrl after enable chain", ctrl_word, 32'h000D007F);
    repeat (5) @(negedge clk);
    status[7] = 1'b1;
    while (!ctrl_word[7]) @(negedge clk);
    check(ctrl_word == 32'h000D0FFF, "R5 ctrl after poll", ctrl_word, 32'h000D0FFF);
    check(timeout == 1'b0, "R3 no timeout on late ready", 32'(timeout), 0);
    while (!aux_en) @(negedge clk);
    check(pll_word == 32'h39dc5040 && clk_word == 32'h80084343, "R6 words at aux", pll_word, 32'h39dc5040);
    wait_done();
    check(pll_word == 32'hFBDC506B, "R7 normal band merge", pll_word, 32'hFBDC506B);
    repeat (30) @(negedge clk);
    check(ndone - d0 == 1, "R10 one completion only", 32'(ndone - d0), 32'd1);
    check(ctrl_word == 32'h01FF0F7F, "R10 no restart", ctrl_word, 32'h01FF0F7F);

    // Scenario B: ready never comes
    run_simple({3'b0, 6'h05, 11'h000}, 1'b0, 32'hFBDC5045, 1'b1, "R4 R7 pll after timeout");
    // Scenario C/D: high band, saturating and plain bump
    run_simple({3'b0, 6'h3e, 11'h080}, 1'b1, 32'hFBDC507F, 1'b0, "R8 saturate at 0x3f");
    run_simple({3'b0, 6'h10, 11'h080}, 1'b1, 32'hFBDC5052, 1'b0, "R8 bump by two");
    run_simple({3'b0, 6'h3d, 11'h080}, 1'b1, 32'hFBDC507F, 1'b0, "R8 boundary 0x3d");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule